// File: doc/BRIEF.md
# Multi-Mode GPIO Port with Pin Interrupts

This block is an eight-pin (parameterised) general-purpose I/O port. Every pin is configured on its own by one bit in each of four registers: a stored data bit, a direction bit and two selector bits. The three bits {sel2, sel1, dir} are decoded jointly into one of eight pin modes: push-pull output, input, open-drain, open-source, reserved tristate, dual-edge interrupt, alternate-function handoff and pin interrupt. In the pin-interrupt mode, a fifth per-pin trigger bit chooses level or single-edge behaviour. The stored data bit then picks the polarity or the edge.

Pin inputs pass through a synchronizer, followed by one history flop for edge detection. Each pin has a small request state machine with two states, `RQ_IDLE` and `RQ_PEND`. The transition `RQ_IDLE -> RQ_PEND` happens on a qualifying edge event. The transition `RQ_PEND -> RQ_IDLE` happens on a write-one-to-clear of that pin's status bit, provided no new event arrives in the same cycle. Level requests are not latched: they follow the synchronized pin. The single interrupt output is the OR of all requests.

The port connects to pads through per-pin output-enable, output-value and input lines. Alternate-function logic drives the pin through its own output-enable and value lines.

Top module: `gpio_port`

## Requirements
- R1: Register addresses are: 0 data, 1 direction, 2 sel1, 3 sel2, 4 trigger, 5 status. After reset, direction reads all ones and sel1, sel2 and trigger read zero. Every pin is then in input mode, `pin_oe` is zero and `irq` is low.
- R2: Mode {sel2,sel1,dir}=000 (push-pull) drives the pin: `pin_oe` is 1 and `pin_out` equals the stored data bit.
- R3: Mode 001 (input) leaves `pin_oe` at 0 whatever the stored data bit is.
- R4: A read of address 0 returns the synchronized pin levels, not the stored data bits, in every mode. The value is valid two clocks after the pin changes.
- R5: Mode 010 (open-drain) gives `pin_oe` = NOT data and `pin_out` = 0 while enabled. A stored 0 pulls the pin low and a stored 1 floats it.
- R6: Mode 011 (open-source) gives `pin_oe` = data and `pin_out` = 1 while enabled. A stored 1 drives the pin high and a stored 0 floats it.
- R7: Mode 100 (reserved) leaves `pin_oe` at 0.
- R8: Mode 110 (alternate) copies `alt_oe` and `alt_out` to `pin_oe` and `pin_out`.
- R9: Mode 101 (dual edge) latches a request on both rising and falling pin transitions, with `pin_oe` at 0.
- R10: Mode 111 with trigger bit 1 (single edge) latches a request on a rising edge when data is 1 and on a falling edge when data is 0. The opposite edge has no effect.
- R11: Mode 111 with trigger bit 0 (level) requests while the synchronized pin equals the data bit: 1 means active-high and 0 means active-low. The request follows the pin and is not cleared by a status write.
- R12: A latched edge request holds until 1 is written to its bit at address 5. Writing 0 to that bit leaves the request in place.
- R13: A read of address 5 returns the OR of latched and level requests per pin, and `irq` is high exactly when any request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data (combinational on address) |
| pin_in | input | W | Pad input levels |
| pin_oe | output | W | Pad output enables |
| pin_out | output | W | Pad output values |
| alt_oe | input | W | Alternate-function output enables |
| alt_out | input | W | Alternate-function output values |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with W=8 and SYNC_STAGES=2. The 8-bit width lets a single register write place different pins in opposite polarities or edges, so rising and falling behaviour is compared in the same cycle. The two-stage synchronizer keeps pin-to-request latency at three clocks, so clear-versus-hold and level-follow behaviour can be observed within a few cycles of each stimulus.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [2:0] {
        PM_PUSH   = 3'b000,
        PM_INPUT  = 3'b001,
        PM_ODRAIN = 3'b010,
        PM_OSRC   = 3'b011,
        PM_RSVD   = 3'b100,
        PM_DUAL   = 3'b101,
        PM_ALT    = 3'b110,
        PM_IRQ    = 3'b111
    } pin_mode_e;

    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_PEND = 1'b1
    } req_state_e;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_SEL1 = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_SEL2 = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_TRIG = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd5;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= din;
    end

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[k] <= '0;
                else        chain[k] <= chain[k-1];
            end
        end
    endgenerate

    assign dout = chain[LAST];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_lvl,
    input  logic [W-1:0]      req_vec,
    output logic [W-1:0]      r_data,
    output logic [W-1:0]      r_dir,
    output logic [W-1:0]      r_sel1,
    output logic [W-1:0]      r_sel2,
    output logic [W-1:0]      r_trig,
    output logic [W-1:0]      clr_mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_data <= '0;
            r_dir  <= '1;
            r_sel1 <= '0;
            r_sel2 <= '0;
            r_trig <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADR_DATA: r_data <= bus_wdata;
                ADR_DIR:  r_dir  <= bus_wdata;
                ADR_SEL1: r_sel1 <= bus_wdata;
                ADR_SEL2: r_sel2 <= bus_wdata;
                ADR_TRIG: r_trig <= bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        clr_mask = (bus_wr && bus_addr == ADR_STAT) ? bus_wdata : '0;
    end

    always_comb begin
        case (bus_addr)
            ADR_DATA: bus_rdata = pin_lvl;
            ADR_DIR:  bus_rdata = r_dir;
            ADR_SEL1: bus_rdata = r_sel1;
            ADR_SEL2: bus_rdata = r_sel2;
            ADR_TRIG: bus_rdata = r_trig;
            ADR_STAT: bus_rdata = req_vec;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_port_pkg::*;
(
    input  logic sel2,
    input  logic sel1,
    input  logic dir,
    input  logic data,
    input  logic trig,
    input  logic alt_oe,
    input  logic alt_out,
    input  logic lvl,
    input  logic lvl_prev,
    output logic oe,
    output logic out,
    output logic edge_evt,
    output logic lvl_req
);
    pin_mode_e mode;
    logic      rise;
    logic      fall;

    always_comb begin
        mode = pin_mode_e'({sel2, sel1, dir});
        rise = lvl & ~lvl_prev;
        fall = ~lvl & lvl_prev;
    end

    always_comb begin
        oe       = 1'b0;
        out      = 1'b0;
        edge_evt = 1'b0;
        lvl_req  = 1'b0;
        unique case (mode)
            PM_PUSH: begin
                oe  = 1'b1;
                out = data;
            end
            PM_INPUT: ;
            PM_ODRAIN: begin
                oe  = ~data;
                out = 1'b0;
            end
            PM_OSRC: begin
                oe  = data;
                out = 1'b1;
            end
            PM_RSVD: ;
            PM_DUAL: edge_evt = rise | fall;
            PM_ALT: begin
                oe  = alt_oe;
                out = alt_out;
            end
            PM_IRQ: begin
                if (trig) edge_evt = data ? rise : fall;
                else      lvl_req  = (lvl == data);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gpio_req_fsm.sv
module gpio_req_fsm
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic pend
);
    req_state_e state;
    req_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            RQ_IDLE: if (evt)         state_nx = RQ_PEND;
            RQ_PEND: if (clr && !evt) state_nx = RQ_IDLE;
            default:                  state_nx = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        pend = (state == RQ_PEND);
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_out,
    input  logic [W-1:0]      alt_oe,
    input  logic [W-1:0]      alt_out,
    output logic              irq
);
    logic [W-1:0] r_data;
    logic [W-1:0] r_dir;
    logic [W-1:0] r_sel1;
    logic [W-1:0] r_sel2;
    logic [W-1:0] r_trig;
    logic [W-1:0] clr_mask;
    logic [W-1:0] lvl_sync;
    logic [W-1:0] lvl_prev;
    logic [W-1:0] edge_evt;
    logic [W-1:0] lvl_req;
    logic [W-1:0] edge_pend;
    logic [W-1:0] req_vec;

    gpio_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_lvl   (lvl_sync),
        .req_vec   (req_vec),
        .r_data    (r_data),
        .r_dir     (r_dir),
        .r_sel1    (r_sel1),
        .r_sel2    (r_sel2),
        .r_trig    (r_trig),
        .clr_mask  (clr_mask)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (lvl_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev <= '0;
        else        lvl_prev <= lvl_sync;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            gpio_pin_ctl u_ctl (
                .sel2     (r_sel2[i]),
                .sel1     (r_sel1[i]),
                .dir      (r_dir[i]),
                .data     (r_data[i]),
                .trig     (r_trig[i]),
                .alt_oe   (alt_oe[i]),
                .alt_out  (alt_out[i]),
                .lvl      (lvl_sync[i]),
                .lvl_prev (lvl_prev[i]),
                .oe       (pin_oe[i]),
                .out      (pin_out[i]),
                .edge_evt (edge_evt[i]),
                .lvl_req  (lvl_req[i])
            );

            gpio_req_fsm u_req (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (edge_evt[i]),
                .clr   (clr_mask[i]),
                .pend  (edge_pend[i])
            );
        end
    endgenerate

    always_comb begin
        req_vec = edge_pend | lvl_req;
        irq     = |req_vec;
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      alt_oe,
    input logic [W-1:0]      alt_out,
    input logic [W-1:0]      r_data,
    input logic [W-1:0]      r_dir,
    input logic [W-1:0]      r_sel1,
    input logic [W-1:0]      r_sel2,
    input logic [W-1:0]      edge_pend,
    input logic              irq
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_chk
            // R2
            push_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ({r_sel2[i], r_sel1[i], r_dir[i]} == 3'b000) |-> (pin_oe[i] && pin_out[i] == r_data[i]));

            // R3
            input_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ({r_sel2[i], r_sel1[i], r_dir[i]} == 3'b001) |-> !pin_oe[i]);

            // R5
            drain_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ({r_sel2[i], r_sel1[i], r_dir[i]} == 3'b010) |-> (pin_oe[i] != r_data[i] && !(pin_oe[i] && pin_out[i])));

            // R6
            source_high_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ({r_sel2[i], r_sel1[i], r_dir[i]} == 3'b011) |-> (pin_oe[i] == r_data[i] && !(pin_oe[i] && !pin_out[i])));

            // R7
            reserved_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ({r_sel2[i], r_sel1[i], r_dir[i]} == 3'b100) |-> !pin_oe[i]);

            // R8
            alt_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ({r_sel2[i], r_sel1[i], r_dir[i]} == 3'b110) |-> (pin_oe[i] == alt_oe[i] && pin_out[i] == alt_out[i]));

            // R12
            pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_pend[i] && !(bus_wr && bus_addr == ADR_STAT && bus_wdata[i])) |=> edge_pend[i]);
        end
    endgenerate

    // R13
    irq_covers_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pend != '0) |-> irq);

endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .alt_oe    (alt_oe),
    .alt_out   (alt_out),
    .r_data    (r_data),
    .r_dir     (r_dir),
    .r_sel1    (r_sel1),
    .r_sel2    (r_sel2),
    .edge_pend (edge_pend),
    .irq       (irq)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_oe;
    logic [W-1:0] pin_out;
    logic [W-1:0] alt_oe = '0;
    logic [W-1:0] alt_out = '0;
    logic         irq;

    int n_run  = 0;
    int n_fail = 0;

    gpio_port #(.W(W), .SYNC_STAGES(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out),
        .alt_oe    (alt_oe),
        .alt_out   (alt_out),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick(1);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mode_set(input logic [W-1:0] s2, input logic [W-1:0] s1, input logic [W-1:0] dr);
        wr(3'd3, s2);
        wr(3'd2, s1);
        wr(3'd1, dr);
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        rd(3'd1, v); check("R1 dir", v, 8'hFF);
        rd(3'd2, v); check("R1 sel1", v, 8'h00);
        rd(3'd3, v); check("R1 sel2", v, 8'h00);
        rd(3'd4, v); check("R1 trig", v, 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_push_input();
        logic [W-1:0] v;
        wr(3'd0, 8'hA5);
        check("R3 data ignored in input", pin_oe, 8'h00);
        pin_in = 8'h5A;
        tick(3);
        rd(3'd0, v); check("R4 read pins in input", v, 8'h5A);
        mode_set(8'h00, 8'h00, 8'h00);
        check("R2 oe", pin_oe, 8'hFF);
        check("R2 out", pin_out, 8'hA5);
        pin_in = 8'h0F;
        tick(3);
        rd(3'd0, v); check("R4 read pins in output", v, 8'h0F);
    endtask

    task automatic t_drain_source();
        mode_set(8'h00, 8'hFF, 8'h00);
        wr(3'd0, 8'h0F);
        check("R5 oe", pin_oe, 8'hF0);
        check("R5 low", pin_out & pin_oe, 8'h00);
        mode_set(8'h00, 8'hFF, 8'hFF);
        check("R6 oe", pin_oe, 8'h0F);
        check("R6 high", pin_out & pin_oe, 8'h0F);
    endtask

    task automatic t_reserved_alt();
        logic [W-1:0] v;
        mode_set(8'hFF, 8'h00, 8'h00);
        wr(3'd0, 8'hFF);
        check("R7 oe", pin_oe, 8'h00);
        alt_oe  = 8'h33;
        alt_out = 8'h55;
        mode_set(8'hFF, 8'hFF, 8'h00);
        tick(1);
        check("R8 oe", pin_oe, 8'h33);
        check("R8 out", pin_out, 8'h55);
        pin_in = 8'hC3;
        tick(3);
        rd(3'd0, v); check("R4 read pins in alt", v, 8'hC3);
    endtask

    task automatic t_dual();
        logic [W-1:0] v;
        pin_in = 8'h00;
        mode_set(8'hFF, 8'h00, 8'hFF);
        tick(4);
        wr(3'd5, 8'hFF);
        rd(3'd5, v); check("R9 cleared", v, 8'h00);
        check("R9 oe", pin_oe, 8'h00);
        pin_in = 8'h01;
        tick(4);
        rd(3'd5, v); check("R9 rise", v, 8'h01);
        check("R13 irq on pend", {7'd0, irq}, 8'h01);
        wr(3'd5, 8'hFE);
        tick(1);
        rd(3'd5, v); check("R12 write 0 keeps", v, 8'h01);
        wr(3'd5, 8'h01);
        rd(3'd5, v); check("R12 write 1 clears", v, 8'h00);
        check("R13 irq low", {7'd0, irq}, 8'h00);
        pin_in = 8'h00;
        tick(4);
        rd(3'd5, v); check("R9 fall", v, 8'h01);
        wr(3'd5, 8'hFF);
    endtask

    task automatic t_single();
        logic [W-1:0] v;
        pin_in = 8'h02;
        wr(3'd4, 8'hFF);
        wr(3'd0, 8'h01);
        wr(3'd2, 8'hFF);
        tick(4);
        wr(3'd5, 8'hFF);
        rd(3'd5, v); check("R10 start clear", v, 8'h00);
        pin_in = 8'h01;
        tick(4);
        rd(3'd5, v); check("R10 rise0 fall1", v, 8'h03);
        wr(3'd5, 8'hFF);
        pin_in = 8'h02;
        tick(4);
        rd(3'd5, v); check("R10 opposite edges ignored", v, 8'h00);
        check("R10 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_level();
        logic [W-1:0] v;
        wr(3'd4, 8'h00);
        wr(3'd0, 8'hFD);
        tick(4);
        rd(3'd5, v); check("R11 idle", v, 8'h00);
        pin_in = 8'h00;
        tick(4);
        rd(3'd5, v); check("R11 active low", v, 8'h02);
        check("R13 irq level", {7'd0, irq}, 8'h01);
        wr(3'd5, 8'h02);
        rd(3'd5, v); check("R11 not cleared", v, 8'h02);
        pin_in = 8'h03;
        tick(4);
        rd(3'd5, v); check("R11 follows pin", v, 8'h01);
        check("R13 irq still", {7'd0, irq}, 8'h01);
        pin_in = 8'h02;
        tick(4);
        rd(3'd5, v); check("R13 none", v, 8'h00);
        check("R13 irq idle", {7'd0, irq}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_push_input();
        t_drain_source();
        t_reserved_alt();
        t_dual();
        t_single();
        t_level();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule